// File: doc/BRIEF.md
# Direct-Mapped Page Translation Cache

This block keeps a small set of recently used page translations. Each translation maps a 20-bit virtual page number to a 20-bit physical frame number and 3 permission bits. The caller sends a page number on the lookup port. One cycle later it gets a registered answer: hit or miss, and on a hit the frame number and permissions. When a miss has been resolved by a page-table walk somewhere else, the walker writes the translation through the fill port. A flush input drops every translation at once.

The cache is direct mapped with 16 slots. A page can live in only one slot. That slot is chosen by XORing the lowest four page-number bits with the highest four. This keeps pages that differ only in their upper bits, such as code near the bottom of the address space and stack near the top, out of the same slot. Because the hash is many-to-one, each slot stores the whole page number as its tag, so a page that aliases into an occupied slot never hits falsely.

Top module: `dm_xlate_cache`

## Requirements
- R1: While reset is asserted and after it is released, the response outputs are all zero. Every slot starts invalid, so the first lookup of any page misses.
- R2: `rsp_vld` is high in the cycle after `lk_req` is high, and low in the cycle after `lk_req` is low.
- R3: A lookup of a page that an earlier fill installed, and that has not since been displaced, responds with `rsp_hit`=1 and the stored frame and permission values.
- R4: Whenever `rsp_hit` is 0, `rsp_pfn` and `rsp_perm` are 0.
- R5: The slot of page number v is (v[3:0] XOR v[19:16]). Pages 0x00009 (slot 9) and 0x10009 (slot 8) share their low bits but can be held at the same time.
- R6: The tag is the full page number. A lookup of a page that maps to an occupied slot holding a different page misses (example: 0x30001 against a stored 0x00002, both slot 2).
- R7: A fill replaces whatever entry occupies its slot. Example: filling 0x00002 after 0x10003 (both slot 2) makes 0x10003 miss.
- R8: A lookup sees the contents as they were before any fill in the same cycle. A lookup of the page being filled in that cycle misses, and the same page hits from the next cycle.
- R9: A flush invalidates every slot in one cycle. A lookup issued in the flush cycle still sees the old contents, and lookups from the following cycle miss.
- R10: When flush and fill are asserted in the same cycle, the flush wins and the fill is discarded.
- R11: With no lookup request, the next cycle's `rsp_vld` and `rsp_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Page number to look up |
| fl_en | input | 1 | Fill enable |
| fl_vpn | input | 20 | Page number to install |
| fl_pfn | input | 20 | Frame number to install |
| fl_perm | input | 3 | Permission bits to install |
| flush | input | 1 | Invalidate all slots |
| rsp_vld | output | 1 | Registered response valid |
| rsp_hit | output | 1 | Registered hit indication |
| rsp_pfn | output | 20 | Frame number on a hit, else 0 |
| rsp_perm | output | 3 | Permission bits on a hit, else 0 |

## Verification
Every response comes exactly one clock after its request. Fills and flushes change the stored contents at the same edge, so they first affect a lookup issued in the following cycle. The bench applies one set of inputs per cycle at the falling edge. It updates its own slot model with that cycle's fill or flush only after it has predicted the lookup answer from the pre-edge contents. It then compares all four response outputs at the next falling edge, which is one register stage after the inputs were applied.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int DEF_VPN_W  = 20;
  localparam int DEF_PFN_W  = 20;
  localparam int DEF_PERM_W = 3;
  localparam int DEF_SLOTS  = 16;

  typedef enum logic [1:0] {
    OUT_IDLE = 2'd0,
    OUT_MISS = 2'd1,
    OUT_HIT  = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/xc_slot_hash.sv
module xc_slot_hash #(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] lo_bits,
  input  logic [IDX_W-1:0] hi_bits,
  output logic [IDX_W-1:0] slot
);
  function automatic logic [IDX_W-1:0] fold(input logic [IDX_W-1:0] a,
                                            input logic [IDX_W-1:0] b);
    return a ^ b;
  endfunction

  assign slot = fold(lo_bits, hi_bits);
endmodule

// File: rtl/xc_entry_store.sv
module xc_entry_store #(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int PERM_W = 3,
  parameter int SLOTS  = 16,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_tag,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [VPN_W-1:0]  rd_tag,
  output logic [PFN_W-1:0]  rd_pfn,
  output logic [PERM_W-1:0] rd_perm
);
  logic [SLOTS-1:0]  vld_q;
  logic [VPN_W-1:0]  tag_q  [SLOTS];
  logic [PFN_W-1:0]  pfn_q  [SLOTS];
  logic [PERM_W-1:0] perm_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) begin
        vld_q[g] <= 1'b0;
      end else if (sel) begin
        vld_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[g]  <= '0;
        pfn_q[g]  <= '0;
        perm_q[g] <= '0;
      end else if (sel && !clr_all) begin
        tag_q[g]  <= wr_tag;
        pfn_q[g]  <= wr_pfn;
        perm_q[g] <= wr_perm;
      end
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_pfn   = pfn_q[rd_idx];
  assign rd_perm  = perm_q[rd_idx];
endmodule

// File: rtl/xc_resp_stage.sv
module xc_resp_stage
  import xc_pkg::*;
#(
  parameter int PFN_W  = 20,
  parameter int PERM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              match,
  input  logic [PFN_W-1:0]  pfn_in,
  input  logic [PERM_W-1:0] perm_in,
  output logic              vld,
  output logic              hit,
  output logic [PFN_W-1:0]  pfn,
  output logic [PERM_W-1:0] perm
);
  rsp_kind_e kind_d;

  always_comb begin
    if (!req)       kind_d = OUT_IDLE;
    else if (match) kind_d = OUT_HIT;
    else            kind_d = OUT_MISS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      hit  <= 1'b0;
      pfn  <= '0;
      perm <= '0;
    end else begin
      vld  <= (kind_d != OUT_IDLE);
      hit  <= (kind_d == OUT_HIT);
      pfn  <= (kind_d == OUT_HIT) ? pfn_in  : '0;
      perm <= (kind_d == OUT_HIT) ? perm_in : '0;
    end
  end
endmodule

// File: rtl/dm_xlate_cache.sv
module dm_xlate_cache
  import xc_pkg::*;
#(
  parameter int VPN_W  = DEF_VPN_W,
  parameter int PFN_W  = DEF_PFN_W,
  parameter int PERM_W = DEF_PERM_W,
  parameter int SLOTS  = DEF_SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              fl_en,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [PFN_W-1:0]  fl_pfn,
  input  logic [PERM_W-1:0] fl_perm,
  input  logic              flush,
  output logic              rsp_vld,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [PERM_W-1:0] rsp_perm
);
  localparam int IDX_W = $clog2(SLOTS);

  // Named internal events, observed by the bound checker
  logic [IDX_W-1:0]  lk_slot;
  logic [IDX_W-1:0]  fl_slot;
  logic              fill_commit;
  logic              lk_match;
  logic              rd_valid;
  logic [VPN_W-1:0]  rd_tag;
  logic [PFN_W-1:0]  rd_pfn;
  logic [PERM_W-1:0] rd_perm;

  xc_slot_hash #(.IDX_W(IDX_W)) u_lk_hash (
    .lo_bits (lk_vpn[IDX_W-1:0]),
    .hi_bits (lk_vpn[VPN_W-1 -: IDX_W]),
    .slot    (lk_slot)
  );

  xc_slot_hash #(.IDX_W(IDX_W)) u_fl_hash (
    .lo_bits (fl_vpn[IDX_W-1:0]),
    .hi_bits (fl_vpn[VPN_W-1 -: IDX_W]),
    .slot    (fl_slot)
  );

  // flush has priority over a simultaneous fill
  assign fill_commit = fl_en && !flush;

  xc_entry_store #(
    .VPN_W (VPN_W),
    .PFN_W (PFN_W),
    .PERM_W(PERM_W),
    .SLOTS (SLOTS)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (flush),
    .wr_en   (fill_commit),
    .wr_idx  (fl_slot),
    .wr_tag  (fl_vpn),
    .wr_pfn  (fl_pfn),
    .wr_perm (fl_perm),
    .rd_idx  (lk_slot),
    .rd_valid(rd_valid),
    .rd_tag  (rd_tag),
    .rd_pfn  (rd_pfn),
    .rd_perm (rd_perm)
  );

  assign lk_match = rd_valid && (rd_tag == lk_vpn);

  xc_resp_stage #(
    .PFN_W (PFN_W),
    .PERM_W(PERM_W)
  ) u_resp (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (lk_req),
    .match  (lk_match),
    .pfn_in (rd_pfn),
    .perm_in(rd_perm),
    .vld    (rsp_vld),
    .hit    (rsp_hit),
    .pfn    (rsp_pfn),
    .perm   (rsp_perm)
  );
endmodule

// File: rtl/xc_chk.sv
module xc_chk #(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int PERM_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_req,
  input logic [VPN_W-1:0]  lk_vpn,
  input logic              fl_en,
  input logic [VPN_W-1:0]  fl_vpn,
  input logic [PFN_W-1:0]  fl_pfn,
  input logic [PERM_W-1:0] fl_perm,
  input logic              flush,
  input logic              fill_commit,
  input logic              lk_match,
  input logic              rsp_vld,
  input logic              rsp_hit,
  input logic [PFN_W-1:0]  rsp_pfn,
  input logic [PERM_W-1:0] rsp_perm
);
  p_vld_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_vld);

  p_idle_no_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!rsp_vld && !rsp_hit));

  p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_pfn == '0 && rsp_perm == '0));

  p_fill_then_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_commit ##1 (lk_req && lk_vpn == $past(fl_vpn))
    |=> (rsp_hit && rsp_pfn == $past(fl_pfn, 2) && rsp_perm == $past(fl_perm, 2)));

  p_same_cycle_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && fl_en && lk_vpn == fl_vpn && !lk_match) |=> !rsp_hit);

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 lk_req |=> !rsp_hit);

  p_flush_beats_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && fl_en) ##1 (lk_req && lk_vpn == $past(fl_vpn)) |=> !rsp_hit);

  p_hit_has_vld_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_vld);
endmodule

bind dm_xlate_cache xc_chk #(
  .VPN_W (VPN_W),
  .PFN_W (PFN_W),
  .PERM_W(PERM_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_req     (lk_req),
  .lk_vpn     (lk_vpn),
  .fl_en      (fl_en),
  .fl_vpn     (fl_vpn),
  .fl_pfn     (fl_pfn),
  .fl_perm    (fl_perm),
  .flush      (flush),
  .fill_commit(fill_commit),
  .lk_match   (lk_match),
  .rsp_vld    (rsp_vld),
  .rsp_hit    (rsp_hit),
  .rsp_pfn    (rsp_pfn),
  .rsp_perm   (rsp_perm)
);

// File: tb/tb_dm_xlate_cache.sv
module tb_dm_xlate_cache;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic        fl_en = 1'b0;
  logic [19:0] fl_vpn = '0;
  logic [19:0] fl_pfn = '0;
  logic [2:0]  fl_perm = '0;
  logic        flush = 1'b0;
  logic        rsp_vld, rsp_hit;
  logic [19:0] rsp_pfn;
  logic [2:0]  rsp_perm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference: one record per slot
  bit          m_val  [16];
  logic [19:0] m_vpn  [16];
  logic [19:0] m_pfn  [16];
  logic [2:0]  m_perm [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_xlate_cache dut (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_vpn(lk_vpn),
    .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn), .fl_perm(fl_perm),
    .flush(flush),
    .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm)
  );

  function automatic int slot_of(input logic [19:0] v);
    return (int'(v) % 16) ^ (int'(v) >> 16);
  endfunction

  task automatic compare(input string req, input bit ev, input bit eh,
                         input logic [19:0] ep, input logic [2:0] epm);
    checks++;
    if (rsp_vld !== ev || rsp_hit !== eh || rsp_pfn !== ep || rsp_perm !== epm) begin
      errors++;
      $display("FAIL %s: got vld=%0b hit=%0b pfn=%05h perm=%0d, expected vld=%0b hit=%0b pfn=%05h perm=%0d",
               req, rsp_vld, rsp_hit, rsp_pfn, rsp_perm, ev, eh, ep, epm);
    end
  endtask

  // one cycle: drive at falling edge, predict, update model, check at next falling edge
  task automatic step(input bit lk, input logic [19:0] lv,
                      input bit fe, input logic [19:0] fv,
                      input logic [19:0] fp, input logic [2:0] fpm,
                      input bit fl, input string req);
    int s;
    bit eh;
    logic [19:0] ep;
    logic [2:0] epm;
    lk_req = lk; lk_vpn = lv;
    fl_en = fe; fl_vpn = fv; fl_pfn = fp; fl_perm = fpm;
    flush = fl;
    s = slot_of(lv);
    eh = lk && m_val[s] && (m_vpn[s] == lv);
    ep  = eh ? m_pfn[s]  : 20'h0;
    epm = eh ? m_perm[s] : 3'h0;
    if (fl) begin
      for (int i = 0; i < 16; i++) m_val[i] = 0;
    end else if (fe) begin
      s = slot_of(fv);
      m_val[s] = 1; m_vpn[s] = fv; m_pfn[s] = fp; m_perm[s] = fpm;
    end
    @(negedge clk);
    compare(req, lk, eh, ep, epm);
  endtask

  task automatic look(input logic [19:0] v, input string req);
    step(1, v, 0, 20'h0, 20'h0, 3'h0, 0, req);
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p,
                      input logic [2:0] pm, input string req);
    step(0, 20'h0, 1, v, p, pm, 0, req);
  endtask

  initial begin
    int lfsr;
    logic [19:0] pool [6];
    for (int i = 0; i < 16; i++) m_val[i] = 0;
    repeat (3) @(negedge clk);
    compare("R1", 0, 0, 20'h0, 3'h0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1", 0, 0, 20'h0, 3'h0);
    look(20'h12345, "R1");
    step(0, 20'h0, 0, 20'h0, 20'h0, 3'h0, 0, "R11");

    fill(20'h12345, 20'hABCDE, 3'd5, "R11");
    look(20'h12345, "R3");
    step(0, 20'h12345, 0, 20'h0, 20'h0, 3'h0, 0, "R11");

    // same-cycle fill and lookup of one page
    step(1, 20'h00007, 1, 20'h00007, 20'h77777, 3'd3, 0, "R8");
    look(20'h00007, "R8");

    // same low bits, different hashed slots
    fill(20'h00009, 20'h00F09, 3'd1, "R5");
    fill(20'h10009, 20'h10F09, 3'd2, "R5");
    look(20'h00009, "R5");
    look(20'h10009, "R5");

    // overwrite within slot 2
    fill(20'h10003, 20'h33333, 3'd6, "R7");
    look(20'h10003, "R7");
    fill(20'h00002, 20'h22222, 3'd4, "R7");
    look(20'h10003, "R7");
    look(20'h00002, "R7");
    look(20'h30001, "R6");
    look(20'h00002, "R4");

    // flush: lookup in the flush cycle sees old contents
    step(1, 20'h12345, 0, 20'h0, 20'h0, 3'h0, 1, "R9");
    look(20'h12345, "R9");
    look(20'h00009, "R9");

    // flush and fill together
    step(0, 20'h0, 1, 20'h12345, 20'h55555, 3'd7, 1, "R10");
    look(20'h12345, "R10");
    fill(20'h12345, 20'h55555, 3'd7, "R10");
    look(20'h12345, "R3");

    // mixed traffic over a small pool of colliding and distinct pages
    pool[0] = 20'h00002; pool[1] = 20'h30001; pool[2] = 20'h10003;
    pool[3] = 20'hF000F; pool[4] = 20'h0000F; pool[5] = 20'h12345;
    lfsr = 32'h1ACE5;
    for (int k = 0; k < 400; k++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
      step(lfsr[0], pool[(lfsr >> 3) % 6], lfsr[1], pool[(lfsr >> 7) % 6],
           20'(lfsr >> 11), 3'(lfsr >> 5), (lfsr[20:16] == 5'd0), "R7");
    end
    step(0, 20'h0, 0, 20'h0, 20'h0, 3'h0, 0, "R11");

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule